// File: doc/BRIEF.md
# Prebias-Safe Startup Mode Sequencer

This block decides when a step-down converter's power switches may operate and which conduction mode they use, from the moment the converter is enabled until steady state. After enable it keeps both switch permissions low. It waits for a comparator to report that the rising soft-start/reference ramp has reached the feedback voltage. This way an output that already holds a voltage is not pulled down at startup. The first switching action it permits is a low-side-only clock, which charges the bootstrap capacitor. After that both switches are permitted.

A fixed number of clocks after that first low-side clock, the prebias-safe phase ends and the final mode is chosen. A part built for forced PWM only always selects forced PWM. A part that can skip pulses selects skip mode when the inductor-zero flag was seen in the current switching-cycle window. It then re-evaluates that choice once per switching cycle. Separately, each time the block is enabled, a 4-bit sink-current-limit code climbs through four levels, lowest first, and then stays at the top level. Dropping enable returns everything to the off state.

Top module: `startup_mode_seq`

## Requirements
- R1: From enable until `ramp_cross_i` has been sampled high, `hs_allow_o`, `ls_allow_o`, `ls_first_o` and `skip_sel_o` stay 0.
- R2: On the clock after `ramp_cross_i` is first sampled high in the waiting state, `ls_allow_o`=1, `ls_first_o`=1 and `hs_allow_o`=0 for exactly one clock. From the next clock both `hs_allow_o` and `ls_allow_o` are 1 and `ls_first_o` is 0.
- R3: The final mode starts `HANDOVER_CYC` (default 4096) clocks after the clock on which `ls_first_o` was 1. Before then `skip_sel_o` is 0.
- R4: With `skip_variant_i`=1, `skip_sel_o` on entry to the final mode is 1 exactly when `il_zero_i` was sampled high since the last `cyc_tick_i`, counting the handover clock itself.
- R5: With `skip_variant_i`=0, `skip_sel_o` stays 0 in every state, whatever `il_zero_i` does.
- R6: Sink codes, at the Nth clock with enable sampled high: 3 for N=1..32, 7 for N=33..64, 11 for N=65..96, 15 from N=97 on and held. Level k of `N_STEPS` has code (k+1)*2^CODE_W/N_STEPS-1. The code is 0 while disabled.
- R7: In the final mode with `skip_variant_i`=1, `skip_sel_o` changes only on the clock after a `cyc_tick_i` sample. `cyc_tick_i` marks the last clock of a switching cycle. The new value is 1 exactly when `il_zero_i` was sampled high in the window that ends with, and includes, that tick clock.
- R8: Sampling `en_i`=0 drives every output to 0 on the next clock and clears all counters. A later enable restarts the sink-code climb at 3 and again waits for a crossing.
- R9: Synchronous active-high `rst` drives every output to 0 on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Converter enable |
| ramp_cross_i | input | 1 | Soft-start/reference ramp at or above feedback |
| il_zero_i | input | 1 | Inductor current has reached zero |
| cyc_tick_i | input | 1 | Last clock of a switching cycle |
| skip_variant_i | input | 1 | 1: skip-capable part, 0: forced-PWM-only part |
| hs_allow_o | output | 1 | High-side switch permitted |
| ls_allow_o | output | 1 | Low-side switch permitted |
| ls_first_o | output | 1 | Low-side-only first pulse request |
| skip_sel_o | output | 1 | 1: skip mode, 0: forced PWM |
| sink_code_o | output | CODE_W | Sink-current-limit DAC code |

## Verification
Two pairs of events can land on the same clock. The handover clock can also be a switching-cycle tick, and a tick can coincide with the inductor-zero flag. The bench places a tick exactly on the handover clock. It then checks two things: the mode picked there still reflects a zero seen long before, and the window starts afresh after it. It also pulses the zero flag and a tick on one clock, right after a tick-only window that resolved to forced PWM, and checks that this clock's flag selects skip mode.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic [2:0] {
    ST_OFF,
    ST_WAIT,
    ST_FIRST,
    ST_SAFE,
    ST_FINAL
  } seq_state_t;
endpackage

// File: rtl/sink_dac_ramp.sv
module sink_dac_ramp #(
  parameter int CODE_W   = 4,
  parameter int N_STEPS  = 4,
  parameter int STEP_CYC = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  output logic [CODE_W-1:0] code
);
  localparam int LIM   = N_STEPS * STEP_CYC;
  localparam int CNT_W = $clog2(LIM);
  localparam int IDX_W = $clog2(N_STEPS);

  logic [CODE_W-1:0] lvl [N_STEPS];
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx;

  // evenly spaced levels, lowest first
  for (genvar k = 0; k < N_STEPS; k++) begin : g_lvl
    assign lvl[k] = CODE_W'((((k + 1) * (1 << CODE_W)) / N_STEPS) - 1);
  end

  assign idx = IDX_W'(cnt_q / CNT_W'(STEP_CYC));

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
      code  <= '0;
    end else begin
      code <= lvl[idx];
      if (cnt_q != CNT_W'(LIM - 1)) cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/zero_window_mon.sv
module zero_window_mon (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic il_zero_i,
  input  logic tick_i,
  output logic zero_now
);
  logic seen_q;

  // window closes on the tick clock, which still belongs to it
  always_ff @(posedge clk) begin
    if (rst || clr || tick_i) seen_q <= 1'b0;
    else if (il_zero_i)       seen_q <= 1'b1;
  end

  assign zero_now = seen_q | il_zero_i;
endmodule

// File: rtl/handover_timer.sv
module handover_timer #(
  parameter int LIM = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic done
);
  localparam int CNT_W = $clog2(LIM);

  logic [CNT_W-1:0] cnt_q;

  assign done = run && (cnt_q == CNT_W'(LIM - 1));

  always_ff @(posedge clk) begin
    if (rst || !run) cnt_q <= '0;
    else if (!done)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/startup_mode_seq.sv
module startup_mode_seq
  import seq_pkg::*;
#(
  parameter int HANDOVER_CYC = 4096,
  parameter int STEP_CYC     = 32,
  parameter int N_STEPS      = 4,
  parameter int CODE_W       = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic              ramp_cross_i,
  input  logic              il_zero_i,
  input  logic              cyc_tick_i,
  input  logic              skip_variant_i,
  output logic              hs_allow_o,
  output logic              ls_allow_o,
  output logic              ls_first_o,
  output logic              skip_sel_o,
  output logic [CODE_W-1:0] sink_code_o
);
  seq_state_t state_q, state_d;
  logic       hand_done, hand_run, zero_now;

  assign hand_run = en_i && (state_q == ST_FIRST || state_q == ST_SAFE);

  handover_timer #(.LIM(HANDOVER_CYC)) u_hand (
    .clk  (clk),
    .rst  (rst),
    .run  (hand_run),
    .done (hand_done)
  );

  zero_window_mon u_zero (
    .clk       (clk),
    .rst       (rst),
    .clr       (!en_i),
    .il_zero_i (il_zero_i),
    .tick_i    (cyc_tick_i),
    .zero_now  (zero_now)
  );

  sink_dac_ramp #(
    .CODE_W   (CODE_W),
    .N_STEPS  (N_STEPS),
    .STEP_CYC (STEP_CYC)
  ) u_dac (
    .clk  (clk),
    .rst  (rst),
    .run  (en_i),
    .code (sink_code_o)
  );

  always_comb begin
    state_d = state_q;
    if (!en_i) begin
      state_d = ST_OFF;
    end else begin
      case (state_q)
        ST_OFF:   state_d = ST_WAIT;
        ST_WAIT:  if (ramp_cross_i) state_d = ST_FIRST;
        ST_FIRST: state_d = hand_done ? ST_FINAL : ST_SAFE;
        ST_SAFE:  if (hand_done) state_d = ST_FINAL;
        ST_FINAL: state_d = ST_FINAL;
        default:  state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_OFF;
      hs_allow_o <= 1'b0;
      ls_allow_o <= 1'b0;
      ls_first_o <= 1'b0;
      skip_sel_o <= 1'b0;
    end else begin
      state_q    <= state_d;
      hs_allow_o <= (state_d == ST_SAFE) || (state_d == ST_FINAL);
      ls_allow_o <= (state_d == ST_FIRST) || (state_d == ST_SAFE) ||
                    (state_d == ST_FINAL);
      ls_first_o <= (state_d == ST_FIRST);
      if (state_d == ST_FINAL) begin
        if (state_q != ST_FINAL || cyc_tick_i)
          skip_sel_o <= skip_variant_i & zero_now;
      end else begin
        skip_sel_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/startup_mode_seq_chk.sv
module startup_mode_seq_chk #(
  parameter int HANDOVER_CYC = 4096,
  parameter int CODE_W       = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              en_i,
  input logic              ramp_cross_i,
  input logic              cyc_tick_i,
  input logic              skip_variant_i,
  input logic              hs_allow_o,
  input logic              ls_allow_o,
  input logic              ls_first_o,
  input logic              skip_sel_o,
  input logic [CODE_W-1:0] sink_code_o
);
  localparam int SW_W = $clog2(HANDOVER_CYC + 2);

  logic [SW_W-1:0] sw_cnt;

  // clocks with low-side permission since it last went high
  always_ff @(posedge clk) begin
    if (rst || !ls_allow_o)                     sw_cnt <= '0;
    else if (sw_cnt != SW_W'(HANDOVER_CYC + 1)) sw_cnt <= sw_cnt + 1'b1;
  end

  p_wait_cross_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(ls_allow_o) |-> $past(ramp_cross_i));

  p_low_first_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(ls_allow_o) |-> (ls_first_o && !hs_allow_o));

  p_hs_after_ls_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(hs_allow_o) |-> $past(ls_allow_o));

  p_no_early_mode_r3: assert property (@(posedge clk) disable iff (rst)
    skip_sel_o |-> (sw_cnt >= SW_W'(HANDOVER_CYC)));

  p_forced_variant_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(skip_sel_o) |-> $past(skip_variant_i));

  p_code_rises_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(en_i) && !$past(rst) && (sink_code_o != $past(sink_code_o)))
      |-> (sink_code_o > $past(sink_code_o)));

  p_tick_update_r7: assert property (@(posedge clk) disable iff (rst)
    (ls_allow_o && (sw_cnt > SW_W'(HANDOVER_CYC)) &&
     (skip_sel_o != $past(skip_sel_o))) |-> $past(cyc_tick_i));

  p_disable_r8: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (!hs_allow_o && !ls_allow_o && !ls_first_o && !skip_sel_o &&
               sink_code_o == '0));
endmodule

bind startup_mode_seq startup_mode_seq_chk #(
  .HANDOVER_CYC (HANDOVER_CYC),
  .CODE_W       (CODE_W)
) u_chk (
  .clk            (clk),
  .rst            (rst),
  .en_i           (en_i),
  .ramp_cross_i   (ramp_cross_i),
  .cyc_tick_i     (cyc_tick_i),
  .skip_variant_i (skip_variant_i),
  .hs_allow_o     (hs_allow_o),
  .ls_allow_o     (ls_allow_o),
  .ls_first_o     (ls_first_o),
  .skip_sel_o     (skip_sel_o),
  .sink_code_o    (sink_code_o)
);

// File: tb/sim_startup_mode_seq.sv
`timescale 1ns/1ps
module sim_startup_mode_seq;
  localparam int HO = 4096;
  localparam int B  = 3;        // clock index at which enable is driven
  localparam int F  = B + 211;  // first low-side clock
  localparam int G  = F + 4147; // first low-side clock after re-enable

  typedef struct {
    int         at;
    logic [7:0] exp;   // {hs, ls, first, skip, code[3:0]}
    string      req;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en_i = 1'b0, ramp_cross_i = 1'b0, il_zero_i = 1'b0;
  logic cyc_tick_i = 1'b0, skip_variant_i = 1'b1;
  logic hs_allow_o, ls_allow_o, ls_first_o, skip_sel_o;
  logic [3:0] sink_code_o;

  int cyc = 0;
  int total = 0;
  int bad = 0;
  item_t sb[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  startup_mode_seq u0 (
    .clk            (clk),
    .rst            (rst),
    .en_i           (en_i),
    .ramp_cross_i   (ramp_cross_i),
    .il_zero_i      (il_zero_i),
    .cyc_tick_i     (cyc_tick_i),
    .skip_variant_i (skip_variant_i),
    .hs_allow_o     (hs_allow_o),
    .ls_allow_o     (ls_allow_o),
    .ls_first_o     (ls_first_o),
    .skip_sel_o     (skip_sel_o),
    .sink_code_o    (sink_code_o)
  );

  function automatic logic [7:0] mk(logic hs, logic ls, logic fi, logic sk,
                                    logic [3:0] code);
    return {hs, ls, fi, sk, code};
  endfunction

  task automatic push(int at, logic [7:0] exp, string req);
    item_t it;
    it.at = at; it.exp = exp; it.req = req;
    sb.push_back(it);
  endtask

  task automatic at_cyc(int n);
    while (cyc < n) @(negedge clk);
  endtask

  // monitor: compares the design against the queue away from the edge
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].at <= cyc) begin
      item_t it;
      logic [7:0] act;
      it  = sb.pop_front();
      act = {hs_allow_o, ls_allow_o, ls_first_o, skip_sel_o, sink_code_o};
      total++;
      if (it.at < cyc) begin
        bad++;
        $display("FAIL %s at clock %0d: missed, actual=%b expected=%b",
                 it.req, it.at, act, it.exp);
      end else if (act !== it.exp) begin
        bad++;
        $display("FAIL %s at clock %0d: actual=%b expected=%b",
                 it.req, it.at, act, it.exp);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired at clock %0d, expected end by %0d", cyc, G + 4112);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // expected items, in time order
    push(2,       mk(0,0,0,0,4'd0),  "R9 reset state");
    push(B+1,     mk(0,0,0,0,4'd3),  "R6 first level");
    push(B+32,    mk(0,0,0,0,4'd3),  "R6 first level held 32");
    push(B+33,    mk(0,0,0,0,4'd7),  "R6 second level");
    push(B+65,    mk(0,0,0,0,4'd11), "R6 third level");
    push(B+97,    mk(0,0,0,0,4'd15), "R6 top level");
    push(B+100,   mk(0,0,0,0,4'd15), "R1 off before crossing");
    push(B+210,   mk(0,0,0,0,4'd15), "R1 off until crossing sampled");
    push(F,       mk(0,1,1,0,4'd15), "R2 low side first");
    push(F+1,     mk(1,1,0,0,4'd15), "R2 both permitted");
    push(F+HO-1,  mk(1,1,0,0,4'd15), "R3 still prebias-safe");
    push(F+HO,    mk(1,1,0,1,4'd15), "R4 handover picks skip on tick clock");
    push(F+4105,  mk(1,1,0,1,4'd15), "R7 held between ticks");
    push(F+4111,  mk(1,1,0,0,4'd15), "R7 no zero in window");
    push(F+4118,  mk(1,1,0,0,4'd15), "R7 held until tick");
    push(F+4121,  mk(1,1,0,1,4'd15), "R7 zero in window");
    push(F+4131,  mk(1,1,0,0,4'd15), "R7 tick alone");
    push(F+4136,  mk(1,1,0,1,4'd15), "R7 zero on tick clock counts");
    push(F+4141,  mk(0,0,0,0,4'd0),  "R8 disable clears outputs");
    push(F+4146,  mk(0,0,0,0,4'd3),  "R8 re-enable restarts ramp");
    push(G,       mk(0,1,1,0,4'd3),  "R8 waits for crossing again");
    push(G+HO,    mk(1,1,0,0,4'd15), "R5 forced variant at handover");
    push(G+4101,  mk(1,1,0,0,4'd15), "R5 forced variant ignores zero");
    push(G+4111,  mk(0,0,0,0,4'd0),  "R9 reset in final mode");

    // driver
    at_cyc(B);       rst = 1'b0; en_i = 1'b1;
    at_cyc(B+210);   ramp_cross_i = 1'b1;
    at_cyc(F+100);   il_zero_i = 1'b1;
    at_cyc(F+101);   il_zero_i = 1'b0;
    at_cyc(F+HO-1);  cyc_tick_i = 1'b1;
    at_cyc(F+HO);    cyc_tick_i = 1'b0;
    at_cyc(F+4110);  cyc_tick_i = 1'b1;
    at_cyc(F+4111);  cyc_tick_i = 1'b0;
    at_cyc(F+4115);  il_zero_i = 1'b1;
    at_cyc(F+4116);  il_zero_i = 1'b0;
    at_cyc(F+4120);  cyc_tick_i = 1'b1;
    at_cyc(F+4121);  cyc_tick_i = 1'b0;
    at_cyc(F+4130);  cyc_tick_i = 1'b1;
    at_cyc(F+4131);  cyc_tick_i = 1'b0;
    at_cyc(F+4135);  cyc_tick_i = 1'b1; il_zero_i = 1'b1;
    at_cyc(F+4136);  cyc_tick_i = 1'b0; il_zero_i = 1'b0;
    at_cyc(F+4140);  en_i = 1'b0; skip_variant_i = 1'b0; il_zero_i = 1'b1;
    at_cyc(F+4145);  en_i = 1'b1;
    at_cyc(G+4100);  cyc_tick_i = 1'b1;
    at_cyc(G+4101);  cyc_tick_i = 1'b0;
    at_cyc(G+4110);  rst = 1'b1;
    at_cyc(G+4112);

    if (sb.size() != 0) begin
      total++; bad++;
      $display("FAIL scoreboard: actual=%0d items left, expected=0", sb.size());
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule